// File: doc/BRIEF.md
# IO Address Translation Walker

This block turns a device DMA address into a real memory address. It walks two tables in memory: a segment table, indexed by the upper IO address bits (each segment spans 256 MB), and then a page table for that segment. The segment entry picks the page size for its segment and says how long its page table is. Both tables are read through a simple read port. A read request is a single-cycle pulse with a byte address. One response pulse comes back some cycles later with a 64-bit word.

A client offers a request with a valid/ready handshake: IO address, direction (read or write) and requester ID. Only one walk runs at a time. The result is a single-cycle response carrying the real address, a fault code and the page attributes (coherency, ordering and hint), which are passed through unchanged. Faults are also signalled on a separate exception output for a neighbouring exception block.

Translation runs only while two configuration bits are set. When either bit is clear, the block passes addresses straight through.

Top module: `ioat_walker`

## Requirements
- R1: While reset is held and in the cycle after it, `req_ready` is 1, and `rsp_valid`, `exc_valid` and `mem_req_valid` are 0.
- R2: Translation is off unless `cfg_origin` bit 63 and `cfg_cmd` bit 47 are both 1. In that case the response comes in the cycle after acceptance, with the real address equal to the zero-extended IO address, fault code 0 and attributes 0, and no memory read is issued.
- R3: The segment entry is read at byte address ((`cfg_origin` bits RA_W-1:12) shifted left by 12) + 8 × (IO address >> 28). If the entry's bit 63 (valid) is 0, the response has fault code 1 (segment fault) in the cycle after the entry arrives, and no second read is issued.
- R4: The page-size code in segment-entry bits 2:0 selects a page shift: 1 gives 12 (4 KB), 3 gives 16 (64 KB), 5 gives 20 (1 MB) and 7 gives 24 (16 MB). Any other code gives fault code 1.
- R5: The page index is IO address bits 27:0 shifted right by the page shift. If the index is at least (segment-entry bits 11:5 + 1) × 512, the response has fault code 2 (page fault) in the cycle after the segment entry arrives, and no second read is issued.
- R6: The page entry is read at ((segment-entry bits RA_W-1:12) shifted left by 12) + 8 × page index. A write needs page-entry bit 63 and a read needs bit 62; without it the result is fault code 2. An entry with both bits clear therefore faults for either direction.
- R7: On success the real address is the page-entry real address (bits RA_W-1:12, shifted left by 12) with its low page-shift bits replaced by the IO address bits. `rsp_attr` is {bit 61, bits 60:59, bit 11} of the page entry. The response comes in the cycle after the page entry arrives.
- R8: `req_ready` is 0 from the acceptance edge until the response cycle has ended. `rsp_valid` lasts exactly one cycle. At most one memory read is outstanding at a time.
- R9: Every faulting response also raises `exc_valid` in the same cycle. It carries `exc_segment` (1 for a segment fault, 0 for a page fault) together with the request's IO address, direction and requester ID. A faulting response carries real address 0 and attributes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_origin | input | 64 | Segment-table origin: bit 63 enable, bits RA_W-1:12 table base |
| cfg_cmd | input | 64 | Command configuration: bit 47 translate enable |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | IOA_W | IO address to translate |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_id | input | ID_W | Requester ID |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_real_addr | output | RA_W | Translated real address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 segment fault, 2 page fault |
| rsp_attr | output | 4 | {coherency, ordering[1:0], hint} from the page entry |
| mem_req_valid | output | 1 | Table read request pulse |
| mem_req_addr | output | RA_W | Byte address of the 64-bit table word |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 64 | Table read data |
| exc_valid | output | 1 | Fault report strobe |
| exc_segment | output | 1 | 1 segment fault, 0 page fault |
| exc_io_addr | output | IOA_W | IO address of the faulting request |
| exc_write | output | 1 | Direction of the faulting request |
| exc_id | output | ID_W | Requester ID of the faulting request |

## Verification
On every cycle the assertions check the following:
- the handshake discipline: busy after acceptance, single-cycle responses, one table read in flight;
- the bypass path's one-cycle identity response;
- zeroed address and attributes on every fault;
- a legal page shift whenever no segment fault is raised;
- in-page offset bits kept in the translated address.

The choice of table addresses, page-size decoding, length limits, permission checks against direction, attribute extraction and exception contents can only be shown by the bench's scenarios. Those scenarios cover each page size, both directions, entries at and beyond the table length, invalid and unmapped segments, and both bypass conditions.

// File: rtl/ioat_pkg.sv
package ioat_pkg;

    localparam int SEG_SHIFT     = 28;
    localparam int MIN_PG_SHIFT  = 12;
    localparam int PIDX_W        = SEG_SHIFT - MIN_PG_SHIFT;
    localparam int ENT_LOG2      = 9;
    localparam int ORIGIN_EN_BIT = 63;
    localparam int XLATE_EN_BIT  = 47;
    localparam int STE_VALID_BIT = 63;
    localparam int PTE_WR_BIT    = 63;
    localparam int PTE_RD_BIT    = 62;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_SEG  = 2'd1,
        FLT_PAGE = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEG_RD,
        ST_SEG_WT,
        ST_PTE_RD,
        ST_PTE_WT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic       coherent;
        logic [1:0] order;
        logic       hint;
    } attr_t;

    // Returns {legal, shift}
    function automatic logic [5:0] decode_page_size(input logic [2:0] code);
        case (code)
            3'd1:    return {1'b1, 5'd12};
            3'd3:    return {1'b1, 5'd16};
            3'd5:    return {1'b1, 5'd20};
            3'd7:    return {1'b1, 5'd24};
            default: return {1'b0, 5'd12};
        endcase
    endfunction

    function automatic attr_t pte_attr(input logic [63:0] pte);
        attr_t a;
        a.coherent = pte[61];
        a.order    = pte[60:59];
        a.hint     = pte[11];
        return a;
    endfunction

endpackage

// File: rtl/ioat_seg_stage.sv
module ioat_seg_stage
    import ioat_pkg::*;
#(
    parameter int RA_W = 42
) (
    input  logic [63:0]          ste,
    input  logic [SEG_SHIFT-1:0] io_off,
    output logic                 seg_fault,
    output logic                 len_fault,
    output logic [4:0]           pg_shift,
    output logic [RA_W-1:0]      pte_addr
);

    logic [5:0]        dec;
    logic [PIDX_W-1:0] pidx;
    logic [PIDX_W:0]   n_ent;
    logic              unused_ste_bits;

    assign unused_ste_bits = ^{ste[62], ste[61:RA_W], ste[4:3]};

    always_comb begin
        dec       = decode_page_size(ste[2:0]);
        pg_shift  = dec[4:0];
        seg_fault = !ste[STE_VALID_BIT] || !dec[5];
        pidx      = PIDX_W'(io_off >> pg_shift);
        n_ent     = ({{(PIDX_W + 1 - 7){1'b0}}, ste[11:5]} + (PIDX_W + 1)'(1)) << ENT_LOG2;
        len_fault = {1'b0, pidx} >= n_ent;
        pte_addr  = {ste[RA_W-1:12], 12'h000} + RA_W'({pidx, 3'b000});
    end

    always_comb begin
        if (!seg_fault) begin
            assert_shift_legal_R4: assert (pg_shift == 5'd12 || pg_shift == 5'd16 ||
                                           pg_shift == 5'd20 || pg_shift == 5'd24);
        end
    end

endmodule

// File: rtl/ioat_page_stage.sv
module ioat_page_stage
    import ioat_pkg::*;
#(
    parameter int RA_W = 42
) (
    input  logic [63:0]          pte,
    input  logic                 is_write,
    input  logic [4:0]           pg_shift,
    input  logic [SEG_SHIFT-1:0] io_off,
    output logic                 perm_fault,
    output logic [RA_W-1:0]      ra,
    output attr_t                attr
);

    logic [RA_W-1:0] off_mask;
    logic            unused_pte_bits;

    assign unused_pte_bits = ^{pte[58:RA_W], pte[10:0]};

    always_comb begin
        perm_fault = is_write ? !pte[PTE_WR_BIT] : !pte[PTE_RD_BIT];
        off_mask   = (RA_W'(1) << pg_shift) - RA_W'(1);
        ra         = ({pte[RA_W-1:12], 12'h000} & ~off_mask) | (RA_W'(io_off) & off_mask);
        attr       = pte_attr(pte);
    end

    always_comb begin
        if (!$isunknown(io_off) && !$isunknown(pg_shift)) begin
            assert_offset_kept_R7: assert (ra[11:0] == io_off[11:0]);
        end
    end

endmodule

// File: rtl/ioat_walker.sv
module ioat_walker
    import ioat_pkg::*;
#(
    parameter int IOA_W = 36,
    parameter int RA_W  = 42,
    parameter int ID_W  = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [63:0]      cfg_origin,
    input  logic [63:0]      cfg_cmd,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IOA_W-1:0] req_addr,
    input  logic             req_write,
    input  logic [ID_W-1:0]  req_id,
    output logic             rsp_valid,
    output logic [RA_W-1:0]  rsp_real_addr,
    output logic [1:0]       rsp_fault,
    output logic [3:0]       rsp_attr,
    output logic             mem_req_valid,
    output logic [RA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [63:0]      mem_rsp_data,
    output logic             exc_valid,
    output logic             exc_segment,
    output logic [IOA_W-1:0] exc_io_addr,
    output logic             exc_write,
    output logic [ID_W-1:0]  exc_id
);

    localparam int SEG_IDX_W = IOA_W - SEG_SHIFT;

    walk_state_e     state;
    logic [IOA_W-1:0] cap_addr;
    logic             cap_write;
    logic [ID_W-1:0]  cap_id;
    logic [4:0]       pg_shift_q;
    logic [RA_W-1:0]  pte_addr_q;
    fault_e           res_fault;
    logic [RA_W-1:0]  res_ra;
    attr_t            res_attr;

    logic             xlate_on;
    logic [RA_W-1:0]  stab_addr;
    logic             seg_fault, len_fault, perm_fault;
    logic [4:0]       pg_shift;
    logic [RA_W-1:0]  pte_addr, page_ra;
    attr_t            page_attr;
    logic             unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_origin[62:RA_W], cfg_origin[11:0],
                               cfg_cmd[63:XLATE_EN_BIT+1], cfg_cmd[XLATE_EN_BIT-1:0]};

    assign xlate_on  = cfg_origin[ORIGIN_EN_BIT] && cfg_cmd[XLATE_EN_BIT];
    assign stab_addr = {cfg_origin[RA_W-1:12], 12'h000}
                     + RA_W'({cap_addr[IOA_W-1 -: SEG_IDX_W], 3'b000});

    ioat_seg_stage #(.RA_W(RA_W)) u_seg (
        .ste       (mem_rsp_data),
        .io_off    (cap_addr[SEG_SHIFT-1:0]),
        .seg_fault (seg_fault),
        .len_fault (len_fault),
        .pg_shift  (pg_shift),
        .pte_addr  (pte_addr)
    );

    ioat_page_stage #(.RA_W(RA_W)) u_page (
        .pte        (mem_rsp_data),
        .is_write   (cap_write),
        .pg_shift   (pg_shift_q),
        .io_off     (cap_addr[SEG_SHIFT-1:0]),
        .perm_fault (perm_fault),
        .ra         (page_ra),
        .attr       (page_attr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cap_addr   <= '0;
            cap_write  <= 1'b0;
            cap_id     <= '0;
            pg_shift_q <= 5'd12;
            pte_addr_q <= '0;
            res_fault  <= FLT_NONE;
            res_ra     <= '0;
            res_attr   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cap_addr  <= req_addr;
                        cap_write <= req_write;
                        cap_id    <= req_id;
                        if (xlate_on) begin
                            state <= ST_SEG_RD;
                        end else begin
                            res_fault <= FLT_NONE;
                            res_ra    <= RA_W'(req_addr);
                            res_attr  <= '0;
                            state     <= ST_DONE;
                        end
                    end
                end
                ST_SEG_RD: state <= ST_SEG_WT;
                ST_SEG_WT: begin
                    if (mem_rsp_valid) begin
                        if (seg_fault || len_fault) begin
                            res_fault <= seg_fault ? FLT_SEG : FLT_PAGE;
                            res_ra    <= '0;
                            res_attr  <= '0;
                            state     <= ST_DONE;
                        end else begin
                            pte_addr_q <= pte_addr;
                            pg_shift_q <= pg_shift;
                            state      <= ST_PTE_RD;
                        end
                    end
                end
                ST_PTE_RD: state <= ST_PTE_WT;
                ST_PTE_WT: begin
                    if (mem_rsp_valid) begin
                        if (perm_fault) begin
                            res_fault <= FLT_PAGE;
                            res_ra    <= '0;
                            res_attr  <= '0;
                        end else begin
                            res_fault <= FLT_NONE;
                            res_ra    <= page_ra;
                            res_attr  <= page_attr;
                        end
                        state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_SEG_RD) || (state == ST_PTE_RD);
    assign mem_req_addr  = (state == ST_PTE_RD) ? pte_addr_q : stab_addr;
    assign rsp_valid     = (state == ST_DONE);
    assign rsp_real_addr = res_ra;
    assign rsp_fault     = res_fault;
    assign rsp_attr      = res_attr;
    assign exc_valid     = (state == ST_DONE) && (res_fault != FLT_NONE);
    assign exc_segment   = (res_fault == FLT_SEG);
    assign exc_io_addr   = cap_addr;
    assign exc_write     = cap_write;
    assign exc_id        = cap_id;

    // Tracks table reads in flight, for the checks below
    logic rd_pending;
    always_ff @(posedge clk) begin
        if (rst)                rd_pending <= 1'b0;
        else if (mem_req_valid) rd_pending <= 1'b1;
        else if (mem_rsp_valid) rd_pending <= 1'b0;
    end

    assert_one_read_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !rd_pending);

    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !(cfg_origin[ORIGIN_EN_BIT] && cfg_cmd[XLATE_EN_BIT]))
        |=> (rsp_valid && rsp_fault == 2'd0 && !mem_req_valid &&
             rsp_real_addr == RA_W'($past(req_addr))));

    assert_fault_zeroed_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_real_addr == '0 && rsp_attr == 4'd0));

endmodule

// File: tb/ioat_walker_bench.sv
module ioat_walker_bench;

    localparam int IOA_W = 36;
    localparam int RA_W  = 42;
    localparam int ID_W  = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [63:0]      cfg_origin = '0, cfg_cmd = '0;
    logic             req_valid = 1'b0, req_write = 1'b0;
    logic [IOA_W-1:0] req_addr = '0;
    logic [ID_W-1:0]  req_id = '0;
    logic             req_ready, rsp_valid, mem_req_valid;
    logic [RA_W-1:0]  rsp_real_addr, mem_req_addr;
    logic [1:0]       rsp_fault;
    logic [3:0]       rsp_attr;
    logic             mem_rsp_valid = 1'b0;
    logic [63:0]      mem_rsp_data = '0;
    logic             exc_valid, exc_segment, exc_write;
    logic [IOA_W-1:0] exc_io_addr;
    logic [ID_W-1:0]  exc_id;

    ioat_walker #(.IOA_W(IOA_W), .RA_W(RA_W), .ID_W(ID_W)) u_ioat_walker (
        .clk(clk), .rst(rst), .cfg_origin(cfg_origin), .cfg_cmd(cfg_cmd),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_id(req_id), .rsp_valid(rsp_valid),
        .rsp_real_addr(rsp_real_addr), .rsp_fault(rsp_fault), .rsp_attr(rsp_attr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .exc_valid(exc_valid), .exc_segment(exc_segment), .exc_io_addr(exc_io_addr),
        .exc_write(exc_write), .exc_id(exc_id)
    );

    int compared = 0;
    int mismatched = 0;
    int reads = 0;
    logic [63:0] mem [longint unsigned];

    localparam logic [63:0] STAB   = 64'h1_0000;
    localparam logic [63:0] RAMASK = ((64'd1 << RA_W) - 64'd1) & ~64'hFFF;

    function automatic logic [63:0] mem_rd(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'h0;
    endfunction

    // Memory model: answers one cycle after each read request
    always @(posedge clk) begin
        mem_rsp_valid <= mem_req_valid;
        mem_rsp_data  <= mem_req_valid ? mem_rd(64'(mem_req_addr)) : 64'h0;
        if (mem_req_valid) reads <= reads + 1;
    end

    function automatic logic [63:0] mk_ste(input bit v, input logic [63:0] base,
                                           input int len, input int ps);
        return (64'(v) << 63) | (base & RAMASK) | (64'(len) << 5) | 64'(ps);
    endfunction

    function automatic logic [63:0] mk_pte(input bit w, input bit r, input logic [63:0] pa,
                                           input bit c, input int ord, input bit h,
                                           input int id);
        return (64'(w) << 63) | (64'(r) << 62) | (64'(c) << 61) | (64'(ord) << 59)
             | (pa & RAMASK) | (64'(h) << 11) | 64'(id);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference of one walk
    task automatic model(input logic [63:0] a, input bit w, output int f,
                         output logic [63:0] ra, output logic [63:0] at,
                         output int lat, output int nrd);
        logic [63:0] ste, pte, p;
        int sh;
        longint unsigned pidx, cnt;
        f = 0; ra = 0; at = 0;
        if (!(cfg_origin[63] && cfg_cmd[47])) begin
            ra = a; lat = 1; nrd = 0;
            return;
        end
        ste = mem_rd((cfg_origin & RAMASK) + (a >> 28) * 8);
        lat = 3; nrd = 1;
        case (ste[2:0])
            3'd1: sh = 12;
            3'd3: sh = 16;
            3'd5: sh = 20;
            3'd7: sh = 24;
            default: sh = 0;
        endcase
        if (!ste[63] || sh == 0) begin f = 1; return; end
        pidx = (a % (64'd1 << 28)) / (64'd1 << sh);
        cnt  = (longint'(ste[11:5]) + 1) * 512;
        if (pidx >= cnt) begin f = 2; return; end
        pte = mem_rd((ste & RAMASK) + pidx * 8);
        lat = 5; nrd = 2;
        if (!(w ? pte[63] : pte[62])) begin f = 2; return; end
        p  = 64'd1 << sh;
        ra = ((pte & RAMASK) / p) * p + (a % p);
        at = {60'd0, pte[61], pte[60:59], pte[11]};
    endtask

    // Starts and ends at a falling edge with the block idle
    task automatic run(input string tag, input logic [63:0] a, input bit w, input int id);
        int f, lat, nrd, r0;
        logic [63:0] ra, at;
        model(a, w, f, ra, at, lat, nrd);
        r0 = reads;
        req_valid = 1'b1; req_addr = a[IOA_W-1:0]; req_write = w; req_id = id[ID_W-1:0];
        for (int n = 1; n <= lat; n++) begin
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
            chk("R8", "rsp_valid", 64'(rsp_valid), 64'(n == lat));
            chk("R8", "req_ready busy", 64'(req_ready), 64'd0);
            if (n == lat) begin
                chk(tag, "rsp_fault", 64'(rsp_fault), 64'(f));
                chk(tag, "rsp_real_addr", 64'(rsp_real_addr), ra);
                chk(tag, "rsp_attr", 64'(rsp_attr), at);
                chk("R9", "exc_valid", 64'(exc_valid), 64'(f != 0));
                if (f != 0) begin
                    chk("R9", "exc_segment", 64'(exc_segment), 64'(f == 1));
                    chk("R9", "exc_io_addr", 64'(exc_io_addr), a);
                    chk("R9", "exc_write", 64'(exc_write), 64'(w));
                    chk("R9", "exc_id", 64'(exc_id), 64'(id));
                end
            end
        end
        @(negedge clk);
        chk("R8", "req_ready after rsp", 64'(req_ready), 64'd1);
        chk(tag, "table reads", 64'(reads - r0), 64'(nrd));
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // Segment table
        mem[STAB + 0*8]    = mk_ste(1, 64'h10_0000, 0, 1);
        mem[STAB + 1*8]    = mk_ste(1, 64'h20_0000, 0, 3);
        mem[STAB + 2*8]    = mk_ste(1, 64'h30_0000, 1, 5);
        mem[STAB + 3*8]    = mk_ste(1, 64'h40_0000, 0, 7);
        mem[STAB + 4*8]    = mk_ste(0, 64'h50_0000, 0, 1);
        mem[STAB + 5*8]    = mk_ste(1, 64'h50_0000, 0, 2);
        mem[STAB + 255*8]  = mk_ste(1, 64'h10_0000, 0, 1);
        // Page tables
        mem[64'h10_0000 + 1*8]   = mk_pte(1, 1, 64'h2_2222_2000, 0, 1, 0, 3);
        mem[64'h10_0000 + 5*8]   = mk_pte(1, 1, 64'h12_3456_7000, 1, 2, 1, 5);
        mem[64'h10_0000 + 6*8]   = mk_pte(0, 1, 64'h00_00AB_C000, 0, 3, 0, 6);
        mem[64'h10_0000 + 7*8]   = mk_pte(1, 0, 64'h3_0000_0000, 1, 0, 1, 7);
        mem[64'h10_0000 + 8*8]   = mk_pte(0, 0, 64'h3_1111_1000, 1, 3, 1, 8);
        mem[64'h10_0000 + 511*8] = mk_pte(1, 1, 64'h7_7777_7000, 0, 2, 1, 9);
        mem[64'h20_0000 + 3*8]   = mk_pte(1, 1, 64'h5_5551_2000, 1, 1, 0, 1);
        mem[64'h30_0000 + 9*8]   = mk_pte(1, 0, 64'h8_0010_0000, 0, 3, 1, 2);
        mem[64'h40_0000 + 15*8]  = mk_pte(1, 1, 64'h1_2000_0000, 1, 0, 0, 11'h7FF);

        repeat (3) @(negedge clk);
        chk("R1", "req_ready in reset", 64'(req_ready), 64'd1);
        chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "exc_valid", 64'(exc_valid), 64'd0);
        chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);

        // Bypass: origin enable clear, then command enable clear
        cfg_origin = STAB; cfg_cmd = 64'd1 << 47;
        run("R2", 64'hF_1234_5678, 0, 1);
        cfg_origin = (64'd1 << 63) | STAB; cfg_cmd = 64'h0;
        run("R2", 64'h0_0000_5ABC, 1, 2);
        cfg_cmd = 64'd1 << 47;

        // 4 KB segment, permissions against direction
        run("R7", 64'h0_0000_5ABC, 0, 3);
        run("R7", 64'h0_0000_5ABC, 1, 4);
        run("R6", 64'h0_0000_6123, 1, 5);
        run("R6", 64'h0_0000_6123, 0, 6);
        run("R6", 64'h0_0000_7FFF, 0, 7);
        run("R6", 64'h0_0000_7FFF, 1, 8);
        run("R6", 64'h0_0000_8010, 0, 9);
        run("R6", 64'h0_0000_8010, 1, 10);
        // Length boundary: last entry, then one past
        run("R5", 64'h0_001F_F123, 0, 11);
        run("R5", 64'h0_0020_0000, 0, 12);
        // Other page sizes
        run("R4", 64'h0_1003_BEEF, 0, 13);
        run("R5", 64'h0_1258_0000, 1, 14);
        run("R4", 64'h0_2091_2345, 1, 15);
        run("R4", 64'h0_3FAB_CDEF, 0, 16);
        // Segment faults and top segment index
        run("R3", 64'h0_4000_1000, 0, 17);
        run("R4", 64'h0_5000_1000, 1, 18);
        run("R3", 64'h8_0000_0000, 1, 19);
        run("R3", 64'hF_F000_1234, 0, 20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule